// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block sits between a transaction source and an auxiliary-channel transfer engine. It accepts a request descriptor that holds a 4-bit command, a 20-bit target address and a payload length. It checks that the command is legal and that the transfer fits the engine's buffer. It then emits the transmit byte stream: a packed header, followed by the write payload, which is pulled from a separate payload stream. When a request is launched, it also reports to the engine the transmit length, the reply length the engine should expect, and whether the engine must insert a hardware-held key after the header.

On the return path the block parses the reply byte stream for the most recently launched request. It returns the 4-bit reply code. For reads, it forwards the data bytes on a read-data stream and never forwards more than the requested size. For writes, it reports how many bytes were written, using a short-write count when the reply carries one. Retries and the physical link are handled elsewhere. Only one request is in flight on the transmit side at a time.

Top module: `aux_xact_codec`

## Requirements
- R1: Header byte 0 is the command in bits 7:4 and address bits 19:16 in bits 3:0. Header byte 1 is address bits 15:8 and header byte 2 is address bits 7:0. Bytes leave in that order on `tx_data`.
- R2: With a nonzero length, a fourth header byte equal to length minus one follows the address. With a zero length the header is exactly 3 bytes and has no length byte.
- R3: For a write-class command, the payload bytes follow the header in the order taken from the payload stream, and the transmit length is 4 plus the length (3 when the length is zero). `launch_rx_len` is 2. `pl_ready` is raised only in the payload phase while `tx_ready` is high.
- R4: For a read-class command only the header is sent, and `launch_rx_len` is the length plus one.
- R5: The command is legal when, with bit 2 (the middle-of-transaction flag) cleared, it is 4'b0000 (bus write), 4'b0001 (bus read), 4'b0010 (bus write with status update), 4'b1000 (native write) or 4'b1001 (native read). Reads are 4'b0001 and 4'b1001. Any other command gives `rej_valid` with `rej_code` = 1, and no launch and no transmit byte follow.
- R6: A legal request whose transmit length or expected reply length exceeds MAX_XFER (20) gives `rej_valid` with `rej_code` = 2, and no byte is emitted.
- R7: `launch_key_sel` is 1 exactly when the masked command is native write (4'b1000) and the address equals KEY_ADDR (default 20'h68007).
- R8: `rsp_valid` pulses for one cycle in the cycle after the reply byte marked `rx_last` is taken. `rsp_code` is bits 7:4 of the first reply byte.
- R9: For a read reply, the bytes after the first are forwarded on `rd_data`, in order, up to the requested length. Extra bytes are consumed and dropped. `rsp_count` equals the number forwarded.
- R10: For a write reply, `rsp_count` is the second reply byte clamped to the requested length when a second byte exists, and the requested length otherwise. Any further bytes are ignored.
- R11: `tx_last` marks the final transmit byte. `req_ready` is low from the cycle after acceptance until that byte is taken.
- R12: After reset, `req_ready` is 1 and `tx_valid`, `launch_valid`, `rej_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Framer idle, descriptor accepted |
| req_cmd | input | 4 | Request command |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Payload length in bytes |
| pl_valid | input | 1 | Write payload byte valid |
| pl_ready | output | 1 | Write payload byte taken |
| pl_data | input | 8 | Write payload byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Engine takes transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final transmit byte of the request |
| launch_valid | output | 1 | One-cycle pulse when a request starts |
| launch_tx_len | output | CNT_W | Bytes the engine will send |
| launch_rx_len | output | CNT_W | Reply bytes the engine should accept |
| launch_key_sel | output | 1 | Insert hardware key after the header |
| rej_valid | output | 1 | One-cycle pulse when a request is refused |
| rej_code | output | 2 | 1 illegal command, 2 too long |
| rx_valid | input | 1 | Reply byte valid |
| rx_ready | output | 1 | Reply byte taken |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final reply byte |
| rd_valid | output | 1 | Read data byte valid |
| rd_ready | input | 1 | Consumer takes read data byte |
| rd_data | output | 8 | Read data byte |
| rsp_valid | output | 1 | One-cycle pulse when a reply completes |
| rsp_code | output | 4 | Reply code |
| rsp_count | output | LEN_W | Bytes read or written |

## Verification
On every cycle, the assertions check the following. The first transmit byte after a launch carries the command and top address nibble that were accepted. A refusal never overlaps a launch or a transmit byte. No new request is taken while bytes are still leaving. Payload moves only as a one-for-one pass-through to the engine. A reported count never exceeds the requested size, and a key-select launch always expects a write-sized reply. The full header and payload byte order, the exact refusal codes over the whole command space, and the read-forwarding and short-write clamping arithmetic are shown only by the bench sweep. That sweep covers every command code, a range of lengths on both sides of the size limit, several addresses including the key address, and irregular ready and valid patterns.

// File: rtl/aux_codec_pkg.sv
// Shared types and command decode for the auxiliary request codec.
// Assumes a 4-bit command whose bit 2 is the middle-of-transaction flag.
package aux_codec_pkg;

    localparam int unsigned AUX_ADDR_W = 20;
    localparam logic [3:0]  CMD_MASK      = 4'b1011;
    localparam logic [3:0]  CMD_NATIVE_WR = 4'b1000;

    typedef enum logic [1:0] {
        REJ_NONE     = 2'd0,
        REJ_BAD_CMD  = 2'd1,
        REJ_TOO_LONG = 2'd2
    } aux_rej_e;

    typedef enum logic [1:0] {
        KIND_WRITE = 2'd0,
        KIND_READ  = 2'd1,
        KIND_BAD   = 2'd2
    } aux_kind_e;

    // Classify a command once the middle-of-transaction flag is cleared.
    function automatic aux_kind_e aux_kind(input logic [3:0] cmd);
        case (cmd & CMD_MASK)
            4'b0000, 4'b0010, 4'b1000: aux_kind = KIND_WRITE;
            4'b0001, 4'b1001:          aux_kind = KIND_READ;
            default:                   aux_kind = KIND_BAD;
        endcase
    endfunction

endpackage

// File: rtl/aux_req_classify.sv
// Combinational request classifier: derives header length, transmit and
// expected reply lengths, key-select flag and refusal reason.
// Assumes LEN_W small enough that 4 + max length fits in LEN_W+1 bits.
module aux_req_classify
    import aux_codec_pkg::*;
#(
    parameter int unsigned LEN_W    = 5,
    parameter int unsigned CNT_W    = LEN_W + 1,
    parameter int unsigned MAX_XFER = 20,
    parameter logic [AUX_ADDR_W-1:0] KEY_ADDR = 20'h68007
) (
    input  logic [3:0]            cmd,
    input  logic [AUX_ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]      len,
    output aux_kind_e             kind,
    output logic [CNT_W-1:0]      hdr_len,
    output logic [CNT_W-1:0]      tx_len,
    output logic [CNT_W-1:0]      rx_len,
    output logic                  key_sel,
    output aux_rej_e              rej
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_XFER);

    logic len_zero;
    logic [CNT_W-1:0] len_ext;

    // Length and flag derivation from the descriptor.
    always_comb begin
        kind     = aux_kind(cmd);
        len_zero = (len == '0);
        len_ext  = CNT_W'(len);
        hdr_len  = len_zero ? CNT_W'(3) : CNT_W'(4);
        if (kind == KIND_READ) begin
            tx_len = hdr_len;
            rx_len = len_ext + CNT_W'(1);
        end else begin
            tx_len = len_zero ? CNT_W'(3) : (len_ext + CNT_W'(4));
            rx_len = CNT_W'(2);
        end
        key_sel = ((cmd & CMD_MASK) == CMD_NATIVE_WR) && (addr == KEY_ADDR);
        if (kind == KIND_BAD)
            rej = REJ_BAD_CMD;
        else if (tx_len > LIMIT || rx_len > LIMIT)
            rej = REJ_TOO_LONG;
        else
            rej = REJ_NONE;
    end

endmodule

// File: rtl/aux_tx_framer.sv
// Transmit framer: accepts one descriptor at a time, emits header bytes
// then passes write payload through, and announces launch or refusal.
// Assumes the classifier outputs are valid in the same cycle as req_valid.
module aux_tx_framer
    import aux_codec_pkg::*;
#(
    parameter int unsigned LEN_W = 5,
    parameter int unsigned CNT_W = LEN_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [3:0]            req_cmd,
    input  logic [AUX_ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  aux_kind_e             kind,
    input  logic [CNT_W-1:0]      hdr_len,
    input  logic [CNT_W-1:0]      tx_len,
    input  logic [CNT_W-1:0]      rx_len,
    input  logic                  key_sel,
    input  aux_rej_e              rej,
    input  logic                  pl_valid,
    output logic                  pl_ready,
    input  logic [7:0]            pl_data,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [7:0]            tx_data,
    output logic                  tx_last,
    output logic                  launch_valid,
    output logic [CNT_W-1:0]      launch_tx_len,
    output logic [CNT_W-1:0]      launch_rx_len,
    output logic                  launch_key_sel,
    output logic                  rej_valid,
    output logic [1:0]            rej_code,
    output logic                  ctx_read,
    output logic [LEN_W-1:0]      ctx_len
);

    logic                  busy_q;
    logic [CNT_W-1:0]      idx_q;
    logic [3:0]            cmd_q;
    logic [AUX_ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]      len_q;
    logic [CNT_W-1:0]      hdr_len_q;
    logic [CNT_W-1:0]      tx_len_q;
    logic                  accept;
    logic                  in_hdr;
    logic [7:0]            hdr_byte;

    assign req_ready = !busy_q;
    assign accept    = req_valid && !busy_q;

    // Header byte selection by position within the header.
    always_comb begin
        in_hdr = busy_q && (idx_q < hdr_len_q);
        case (idx_q[1:0])
            2'd0:    hdr_byte = {cmd_q, addr_q[19:16]};
            2'd1:    hdr_byte = addr_q[15:8];
            2'd2:    hdr_byte = addr_q[7:0];
            default: hdr_byte = 8'(len_q) - 8'd1;
        endcase
    end

    // Byte stream muxing between header and payload pass-through.
    always_comb begin
        tx_valid = busy_q && (in_hdr || pl_valid);
        tx_data  = in_hdr ? hdr_byte : pl_data;
        pl_ready = busy_q && !in_hdr && tx_ready;
        tx_last  = busy_q && (idx_q == (tx_len_q - CNT_W'(1)));
    end

    // Request acceptance, launch/refusal pulses and byte position tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q         <= 1'b0;
            idx_q          <= '0;
            cmd_q          <= '0;
            addr_q         <= '0;
            len_q          <= '0;
            hdr_len_q      <= '0;
            tx_len_q       <= '0;
            launch_valid   <= 1'b0;
            launch_tx_len  <= '0;
            launch_rx_len  <= '0;
            launch_key_sel <= 1'b0;
            rej_valid      <= 1'b0;
            rej_code       <= 2'd0;
            ctx_read       <= 1'b0;
            ctx_len        <= '0;
        end else begin
            launch_valid <= 1'b0;
            rej_valid    <= 1'b0;
            if (accept) begin
                if (rej != REJ_NONE) begin
                    rej_valid <= 1'b1;
                    rej_code  <= rej;
                end else begin
                    busy_q         <= 1'b1;
                    idx_q          <= '0;
                    cmd_q          <= req_cmd;
                    addr_q         <= req_addr;
                    len_q          <= req_len;
                    hdr_len_q      <= hdr_len;
                    tx_len_q       <= tx_len;
                    launch_valid   <= 1'b1;
                    launch_tx_len  <= tx_len;
                    launch_rx_len  <= rx_len;
                    launch_key_sel <= key_sel;
                    ctx_read       <= (kind == KIND_READ);
                    ctx_len        <= req_len;
                end
            end else if (tx_valid && tx_ready) begin
                if (tx_last)
                    busy_q <= 1'b0;
                else
                    idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/aux_rx_parser.sv
// Reply parser: takes the reply code from the first byte, forwards read
// data up to the requested size, or clamps a short-write count.
// Assumes ctx_read/ctx_len describe the request the reply belongs to
// and that LEN_W is at most 8.
module aux_rx_parser #(
    parameter int unsigned LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctx_read,
    input  logic [LEN_W-1:0] ctx_len,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             rsp_valid,
    output logic [3:0]       rsp_code,
    output logic [LEN_W-1:0] rsp_count
);

    logic             first_q;
    logic [3:0]       code_q;
    logic [LEN_W-1:0] cnt_q;
    logic             seen2_q;
    logic [7:0]       short_q;
    logic             fwd;
    logic             hs;
    logic [7:0]       wr_val;
    logic [7:0]       wr_clamp;
    logic [LEN_W-1:0] rd_cnt_next;

    // Forwarding decision and stream handshakes.
    always_comb begin
        fwd      = ctx_read && !first_q && (cnt_q < ctx_len);
        rd_valid = rx_valid && fwd;
        rd_data  = rx_data;
        rx_ready = fwd ? rd_ready : 1'b1;
        hs       = rx_valid && rx_ready;
    end

    // Completion count arithmetic for both reply kinds.
    always_comb begin
        wr_val      = seen2_q ? short_q : rx_data;
        wr_clamp    = (wr_val > 8'(ctx_len)) ? 8'(ctx_len) : wr_val;
        rd_cnt_next = cnt_q + (fwd ? LEN_W'(1) : LEN_W'(0));
    end

    // Per-reply state and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= 1'b1;
            code_q    <= '0;
            cnt_q     <= '0;
            seen2_q   <= 1'b0;
            short_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            rsp_count <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (hs) begin
                if (rx_last) begin
                    rsp_valid <= 1'b1;
                    rsp_code  <= first_q ? rx_data[7:4] : code_q;
                    if (ctx_read)
                        rsp_count <= rd_cnt_next;
                    else if (!first_q)
                        rsp_count <= LEN_W'(wr_clamp);
                    else
                        rsp_count <= ctx_len;
                    first_q <= 1'b1;
                    cnt_q   <= '0;
                    seen2_q <= 1'b0;
                end else if (first_q) begin
                    code_q  <= rx_data[7:4];
                    first_q <= 1'b0;
                end else if (ctx_read) begin
                    cnt_q <= rd_cnt_next;
                end else if (!seen2_q) begin
                    short_q <= rx_data;
                    seen2_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/aux_xact_codec.sv
// Top: auxiliary-channel request framer and reply parser. Wires the
// classifier, the transmit framer and the reply parser together.
// Assumes one request is framed at a time and replies follow launches.
module aux_xact_codec
    import aux_codec_pkg::*;
#(
    parameter int unsigned LEN_W    = 5,
    parameter int unsigned CNT_W    = LEN_W + 1,
    parameter int unsigned MAX_XFER = 20,
    parameter logic [19:0] KEY_ADDR = 20'h68007
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_cmd,
    input  logic [19:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             pl_valid,
    output logic             pl_ready,
    input  logic [7:0]       pl_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             launch_valid,
    output logic [CNT_W-1:0] launch_tx_len,
    output logic [CNT_W-1:0] launch_rx_len,
    output logic             launch_key_sel,
    output logic             rej_valid,
    output logic [1:0]       rej_code,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             rsp_valid,
    output logic [3:0]       rsp_code,
    output logic [LEN_W-1:0] rsp_count
);

    aux_kind_e        cls_kind;
    logic [CNT_W-1:0] cls_hdr_len;
    logic [CNT_W-1:0] cls_tx_len;
    logic [CNT_W-1:0] cls_rx_len;
    logic             cls_key_sel;
    aux_rej_e         cls_rej;
    logic             ctx_read;
    logic [LEN_W-1:0] ctx_len;

    aux_req_classify #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_XFER(MAX_XFER), .KEY_ADDR(KEY_ADDR)
    ) classify_i (
        .cmd(req_cmd), .addr(req_addr), .len(req_len),
        .kind(cls_kind), .hdr_len(cls_hdr_len), .tx_len(cls_tx_len),
        .rx_len(cls_rx_len), .key_sel(cls_key_sel), .rej(cls_rej)
    );

    aux_tx_framer #(.LEN_W(LEN_W), .CNT_W(CNT_W)) framer_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .kind(cls_kind), .hdr_len(cls_hdr_len), .tx_len(cls_tx_len),
        .rx_len(cls_rx_len), .key_sel(cls_key_sel), .rej(cls_rej),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .launch_valid(launch_valid), .launch_tx_len(launch_tx_len),
        .launch_rx_len(launch_rx_len), .launch_key_sel(launch_key_sel),
        .rej_valid(rej_valid), .rej_code(rej_code),
        .ctx_read(ctx_read), .ctx_len(ctx_len)
    );

    aux_rx_parser #(.LEN_W(LEN_W)) parser_i (
        .clk(clk), .rst_n(rst_n),
        .ctx_read(ctx_read), .ctx_len(ctx_len),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_count(rsp_count)
    );

endmodule

// File: rtl/aux_xact_codec_chk.sv
// Protocol checker for aux_xact_codec, attached by bind below.
module aux_xact_codec_chk #(
    parameter int unsigned LEN_W    = 5,
    parameter int unsigned CNT_W    = LEN_W + 1,
    parameter int unsigned MAX_XFER = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       req_cmd,
    input logic [19:0]      req_addr,
    input logic             req_ready,
    input logic             launch_valid,
    input logic             launch_key_sel,
    input logic [CNT_W-1:0] launch_tx_len,
    input logic [CNT_W-1:0] launch_rx_len,
    input logic             rej_valid,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             pl_valid,
    input logic             pl_ready,
    input logic [7:0]       pl_data,
    input logic             rsp_valid,
    input logic [LEN_W-1:0] rsp_count,
    input logic [LEN_W-1:0] ctx_len
);

    AST_HDR_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> tx_valid && tx_data == {$past(req_cmd), $past(req_addr[19:16])}); // R1

    AST_PL_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && pl_ready) |-> (tx_valid && tx_ready && tx_data == pl_data)); // R3

    AST_REJ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (!tx_valid && !launch_valid)); // R5

    AST_LAUNCH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> (launch_tx_len <= CNT_W'(MAX_XFER) && launch_rx_len <= CNT_W'(MAX_XFER))); // R6

    AST_KEY_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_key_sel) |-> launch_rx_len == CNT_W'(2)); // R7

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_count <= ctx_len); // R10

    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !req_ready); // R11

endmodule

bind aux_xact_codec aux_xact_codec_chk #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_XFER(MAX_XFER)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_ready(req_ready), .launch_valid(launch_valid), .launch_key_sel(launch_key_sel),
    .launch_tx_len(launch_tx_len), .launch_rx_len(launch_rx_len), .rej_valid(rej_valid),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .rsp_valid(rsp_valid), .rsp_count(rsp_count), .ctx_len(ctx_len)
);

// File: tb/aux_xact_codec_tb_top.sv
// Sweep bench: every command code, a spread of lengths and addresses,
// irregular ready/valid patterns, and reply variants for each kind.
module aux_xact_codec_tb_top;

    localparam int LEN_W = 5;
    localparam int CNT_W = 6;
    localparam int MAXX  = 20;
    localparam logic [19:0] KEY = 20'h68007;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [3:0]       req_cmd = '0;
    logic [19:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             pl_valid = 1'b0;
    logic             pl_ready;
    logic [7:0]       pl_data = '0;
    logic             tx_valid;
    logic             tx_ready = 1'b0;
    logic [7:0]       tx_data;
    logic             tx_last;
    logic             launch_valid;
    logic [CNT_W-1:0] launch_tx_len;
    logic [CNT_W-1:0] launch_rx_len;
    logic             launch_key_sel;
    logic             rej_valid;
    logic [1:0]       rej_code;
    logic             rx_valid = 1'b0;
    logic             rx_ready;
    logic [7:0]       rx_data = '0;
    logic             rx_last = 1'b0;
    logic             rd_valid;
    logic             rd_ready = 1'b0;
    logic [7:0]       rd_data;
    logic             rsp_valid;
    logic [3:0]       rsp_code;
    logic [LEN_W-1:0] rsp_count;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] rb [0:63];

    always #2 clk = ~clk;

    aux_xact_codec #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_XFER(MAXX), .KEY_ADDR(KEY)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .launch_valid(launch_valid), .launch_tx_len(launch_tx_len),
        .launch_rx_len(launch_rx_len), .launch_key_sel(launch_key_sel),
        .rej_valid(rej_valid), .rej_code(rej_code),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_count(rsp_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input logic [19:0] a, input int k);
        return a[7:0] + 8'(3 * k + 1);
    endfunction

    task automatic run_req(input logic [3:0] cmd, input logic [19:0] addr, input int len,
                           output bit accepted, output bit is_rd);
        logic [3:0] m;
        bit legal, exp_key;
        int hdr, txl, rxl, exp_rej;
        int n, pidx, cyc, first_bad_n;
        bit fin, busy_bad, hdr_bad, len_bad, pl_bad, last_bad;
        logic [7:0] expb, gotb;
        m = cmd & 4'b1011;
        legal = (m == 4'b0000) || (m == 4'b0001) || (m == 4'b0010) ||
                (m == 4'b1000) || (m == 4'b1001);
        is_rd = (m == 4'b0001) || (m == 4'b1001);
        hdr = (len == 0) ? 3 : 4;
        txl = is_rd ? hdr : ((len == 0) ? 3 : 4 + len);
        rxl = is_rd ? len + 1 : 2;
        exp_key = (m == 4'b1000) && (addr == KEY);
        exp_rej = !legal ? 1 : ((txl > MAXX || rxl > MAXX) ? 2 : 0);
        accepted = (exp_rej == 0);

        @(posedge clk); #1;
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_len = LEN_W'(len);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "idle before request", req_ready, 1);
        @(posedge clk); #1;
        req_valid = 1'b0; req_cmd = ~cmd; req_addr = ~addr; req_len = ~LEN_W'(len);
        pidx = 0; cyc = 0;
        tx_ready = 1'b1; pl_valid = 1'b1; pl_data = pbyte(addr, 0);
        @(negedge clk);
        if (!accepted) begin
            chk(rej_valid && !launch_valid && !tx_valid, (exp_rej == 1) ? "R5" : "R6",
                "refusal pulse without launch or bytes", {rej_valid, launch_valid, tx_valid}, 4);
            chk(rej_code == 2'(exp_rej), (exp_rej == 1) ? "R5" : "R6", "refusal code",
                rej_code, exp_rej);
            tx_ready = 1'b0; pl_valid = 1'b0;
            return;
        end
        chk(launch_valid && !rej_valid, "R5", "legal request launches", launch_valid, 1);
        chk(launch_tx_len == CNT_W'(txl), is_rd ? "R4" : "R3", "launch tx length",
            launch_tx_len, txl);
        chk(launch_rx_len == CNT_W'(rxl), is_rd ? "R4" : "R3", "launch reply length",
            launch_rx_len, rxl);
        chk(launch_key_sel == exp_key, "R7", "key select", launch_key_sel, exp_key);

        n = 0; fin = 0; busy_bad = 0; hdr_bad = 0; len_bad = 0; pl_bad = 0; last_bad = 0;
        first_bad_n = -1; expb = '0; gotb = '0;
        while (1) begin
            if (tx_valid && req_ready) busy_bad = 1;
            if (tx_valid && tx_ready) begin
                if (n == 0)        expb = {cmd, addr[19:16]};
                else if (n == 1)   expb = addr[15:8];
                else if (n == 2)   expb = addr[7:0];
                else if (n == 3 && hdr == 4) expb = 8'(len - 1);
                else               expb = pbyte(addr, n - hdr);
                if (tx_data != expb) begin
                    if (first_bad_n < 0) begin first_bad_n = n; gotb = tx_data; end
                    if (n < 3) hdr_bad = 1;
                    else if (n == 3 && hdr == 4) len_bad = 1;
                    else pl_bad = 1;
                end
                if (tx_last) begin
                    fin = 1;
                    if (n != txl - 1) last_bad = 1;
                end
                n++;
            end
            if (pl_valid && pl_ready) pidx++;
            if (fin || cyc > 200) break;
            @(posedge clk); #1;
            cyc++;
            tx_ready = (cyc % 3) != 1;
            pl_valid = (cyc % 4) != 2;
            pl_data  = pbyte(addr, pidx);
            @(negedge clk);
        end
        @(posedge clk); #1;
        tx_ready = 1'b0; pl_valid = 1'b0;
        chk(!hdr_bad, "R1", "address header bytes", gotb, expb);
        chk(!len_bad, "R2", "length byte", gotb, expb);
        chk(!pl_bad, "R3", "payload bytes in order", gotb, expb);
        chk(n == txl, (len == 0) ? "R2" : (is_rd ? "R4" : "R3"), "transmitted byte count", n, txl);
        chk(pidx == (is_rd ? 0 : len), "R3", "payload bytes consumed", pidx, is_rd ? 0 : len);
        chk(!last_bad && fin, "R11", "last marker on final byte", n, txl);
        chk(!busy_bad, "R11", "ready low while sending", busy_bad, 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready back after final byte", req_ready, 1);
    endtask

    task automatic run_rsp(input bit is_rd, input int len, input int nrx,
                           input logic [7:0] b1, input logic [3:0] code);
        int exp_fwd, exp_cnt, i, nrd, cyc;
        bit fin, rd_bad, rd_spurious;
        rb[0] = {code, 4'h5};
        for (int k = 1; k < 64; k++) rb[k] = is_rd ? 8'(8'h30 + 7 * k) : ((k == 1) ? b1 : 8'hEE);
        exp_fwd = is_rd ? (((nrx - 1) < len) ? nrx - 1 : len) : 0;
        if (is_rd) exp_cnt = exp_fwd;
        else if (nrx >= 2) exp_cnt = (int'(b1) < len) ? int'(b1) : len;
        else exp_cnt = len;
        i = 0; nrd = 0; cyc = 0; fin = 0; rd_bad = 0; rd_spurious = 0;
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = rb[0]; rx_last = (nrx == 1); rd_ready = 1'b1;
        @(negedge clk);
        while (1) begin
            if (rd_valid && !is_rd) rd_spurious = 1;
            if (rd_valid && rd_ready) begin
                if (rd_data != rb[nrd + 1]) rd_bad = 1;
                nrd++;
            end
            if (rx_valid && rx_ready) begin
                if (rx_last) fin = 1;
                i++;
            end
            if (fin || cyc > 300) break;
            @(posedge clk); #1;
            cyc++;
            rx_valid = (cyc % 5) != 3;
            rx_data  = rb[i];
            rx_last  = (i == nrx - 1);
            rd_ready = (cyc % 3) != 2;
            @(negedge clk);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_last = 1'b0; rd_ready = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R8", "completion pulse after last byte", rsp_valid, 1);
        chk(rsp_code == code, "R8", "reply code", rsp_code, code);
        chk(rsp_count == LEN_W'(exp_cnt), is_rd ? "R9" : "R10", "reply count", rsp_count, exp_cnt);
        if (is_rd) begin
            chk(nrd == exp_fwd, "R9", "read bytes forwarded", nrd, exp_fwd);
            chk(!rd_bad, "R9", "read data order", rd_bad, 0);
        end else begin
            chk(!rd_spurious, "R10", "no read data on write reply", rd_spurious, 0);
        end
        @(posedge clk); #1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8", "completion is one cycle", rsp_valid, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] addrs [0:2];
        int lens [0:8];
        bit acc, rd;
        addrs[0] = 20'hA5C3E; addrs[1] = KEY; addrs[2] = 20'h1F00F;
        lens[0] = 0; lens[1] = 1; lens[2] = 2; lens[3] = 5; lens[4] = 15;
        lens[5] = 16; lens[6] = 17; lens[7] = 19; lens[8] = 31;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R12", "reset ready", req_ready, 1);
        chk(!tx_valid && !launch_valid && !rej_valid && !rsp_valid, "R12", "reset outputs idle",
            {tx_valid, launch_valid, rej_valid, rsp_valid}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int a = 0; a < 3; a++) begin
            for (int c = 0; c < 16; c++) begin
                for (int l = 0; l < 9; l++) begin
                    run_req(4'(c), addrs[a], lens[l], acc, rd);
                    if (acc && a != 2) begin
                        logic [3:0] cd;
                        cd = 4'(c) ^ 4'(lens[l]);
                        if (rd) begin
                            run_rsp(1'b1, lens[l], lens[l] + 1, 8'h00, cd);
                            run_rsp(1'b1, lens[l], lens[l] + 3, 8'h00, cd);
                            run_rsp(1'b1, lens[l], 1 + lens[l] / 2, 8'h00, cd);
                        end else begin
                            run_rsp(1'b0, lens[l], 1, 8'h00, cd);
                            run_rsp(1'b0, lens[l], 2, 8'(lens[l] / 2), cd);
                            run_rsp(1'b0, lens[l], 2, 8'(lens[l] + 3), cd);
                            run_rsp(1'b0, lens[l], 3, 8'hFF, cd);
                        end
                    end
                end
            end
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule